// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This controller sits behind a single coin slot that takes nickels and dimes. A coin sensor sends a one-cycle pulse on one of two inputs for each coin. The controller keeps a running credit of 0, 5, 10 or 15 cents. When the credit reaches 15 cents it asserts a release signal that opens the item chute. Any overpayment is absorbed and no change is returned. The credit stays at 15 cents until the surrounding system applies a synchronous reset, which starts a new sale.

The credit is held in a one-hot state register with four named states: CR_ZERO, CR_FIVE, CR_TEN and CR_FULL. The transitions are as follows:

- Idle hold: every state keeps its value when no coin arrives.
- From CR_ZERO: a nickel goes to CR_FIVE, and a dime goes to CR_TEN.
- From CR_FIVE: a nickel goes to CR_TEN, and a dime goes to CR_FULL.
- From CR_TEN: either coin goes to CR_FULL.
- From CR_FULL: it stays there until reset.
- Reset: from any state, reset goes to CR_ZERO.

A pulse on both coin inputs in the same cycle counts as a dime.

Two release outputs are provided:

- A Moore output decoded from the present state.
- A registered output, flopped from the next-state decode. It rises on the same clock edge that enters CR_FULL and comes straight from a flip-flop, so it has no decode logic after the clock.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is CR_ZERO and both release outputs are 0 after that edge. Three nickels are then needed before release.
- R2: Nickels alone move the credit from 0 to 5 to 10 to 15. Release appears after the third nickel and not before.
- R3: A dime from CR_ZERO gives 10 cents. One more nickel then releases.
- R4: A dime from CR_FIVE goes directly to CR_FULL.
- R5: A dime from CR_TEN goes to CR_FULL (20 cents saturates to 15).
- R6: A cycle with neither coin input high leaves the credit unchanged in every state.
- R7: `nickel_in` and `dime_in` high in the same cycle count as one dime. From 0 they give 10 cents, so one further nickel releases.
- R8: Once in CR_FULL, the controller stays there and keeps release high whatever coins arrive, until reset.
- R9: `release_reg` rises on the same edge as `release_moore` and always equals it after reset.
- R10: A reset applied while releasing drops both outputs on that same reset edge.
- R11: The state register always holds exactly one set bit after reset. The encoding is CR_ZERO=0001, CR_FIVE=0010, CR_TEN=0100 and CR_FULL=1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, returns credit to 0 |
| nickel_in | input | 1 | One-cycle pulse per nickel inserted |
| dime_in | input | 1 | One-cycle pulse per dime inserted |
| release_moore | output | 1 | Release decoded from the present state (CR_FULL) |
| release_reg | output | 1 | Release registered from the next-state decode |

## Verification
A coin pulse driven for one cycle changes the state on the next rising edge. Both release outputs reflect the new credit right after that edge, so each result is due one edge after its stimulus. The reset effect is also due one edge after `rst` is applied. The bench drives every input just after a falling edge and samples at the following falling edge. Each check therefore sees exactly one rising edge between its stimulus and its observation. For hold and ignore cases the bench adds idle or coin cycles and samples again at the same spacing.

// File: rtl/vend_pkg.sv
package vend_pkg;
    localparam int CREDIT_W = 4;

    typedef enum logic [CREDIT_W-1:0] {
        CR_ZERO = 4'b0001,
        CR_FIVE = 4'b0010,
        CR_TEN  = 4'b0100,
        CR_FULL = 4'b1000
    } credit_t;
endpackage

// File: rtl/vend_next.sv
module vend_next
    import vend_pkg::*;
(
    input  credit_t state_q,
    input  logic    nickel,
    input  logic    dime,
    output credit_t state_d
);
    logic coin_d;
    logic coin_n;

    // A dime wins over a simultaneous nickel.
    assign coin_d = dime;
    assign coin_n = nickel & ~dime;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CR_ZERO: begin
                if (coin_d)      state_d = CR_TEN;
                else if (coin_n) state_d = CR_FIVE;
            end
            CR_FIVE: begin
                if (coin_d)      state_d = CR_FULL;
                else if (coin_n) state_d = CR_TEN;
            end
            CR_TEN: begin
                if (coin_d | coin_n) state_d = CR_FULL;
            end
            CR_FULL: state_d = CR_FULL;
            default: state_d = CR_ZERO;
        endcase
    end
endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  credit_t state_d,
    output credit_t state_q
);
    always_ff @(posedge clk) begin
        if (rst) state_q <= CR_ZERO;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/vend_release.sv
module vend_release
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  credit_t state_q,
    input  credit_t state_d,
    output logic    rel_moore,
    output logic    rel_reg
);
    always_comb begin
        unique case (state_q)
            CR_FULL: rel_moore = 1'b1;
            default: rel_moore = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rel_reg <= 1'b0;
        else     rel_reg <= (state_d == CR_FULL);
    end
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nickel_in,
    input  logic dime_in,
    output logic release_moore,
    output logic release_reg
);
    credit_t state_q;
    credit_t state_d;

    vend_next u_next (
        .state_q (state_q),
        .nickel  (nickel_in),
        .dime    (dime_in),
        .state_d (state_d)
    );

    vend_state_reg u_sreg (
        .clk     (clk),
        .rst     (rst),
        .state_d (state_d),
        .state_q (state_q)
    );

    vend_release u_rel (
        .clk       (clk),
        .rst       (rst),
        .state_q   (state_q),
        .state_d   (state_d),
        .rel_moore (release_moore),
        .rel_reg   (release_reg)
    );
endmodule

// File: rtl/coin_vend_ctrl_chk.sv
module coin_vend_ctrl_chk
    import vend_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                nickel_in,
    input logic                dime_in,
    input logic                release_moore,
    input logic                release_reg,
    input logic [CREDIT_W-1:0] state_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!release_moore && !release_reg));

    assert_zero_dime_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == CR_ZERO && dime_in) |=> (state_q == CR_TEN));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!nickel_in && !dime_in) |=> $stable(state_q));

    assert_full_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        release_moore |=> release_moore);

    assert_outputs_agree_R9: assert property (@(posedge clk) disable iff (rst)
        release_reg == release_moore);

    assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $countones(state_q) == 1);
endmodule

bind coin_vend_ctrl coin_vend_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .nickel_in     (nickel_in),
    .dime_in       (dime_in),
    .release_moore (release_moore),
    .release_reg   (release_reg),
    .state_q       (state_q)
);

// File: tb/sim_coin_vend_ctrl.sv
`timescale 1ns/1ps
module sim_coin_vend_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel_in = 1'b0;
    logic dime_in = 1'b0;
    logic release_moore;
    logic release_reg;
    int   n_checks = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    coin_vend_ctrl u0 (
        .clk           (clk),
        .rst           (rst),
        .nickel_in     (nickel_in),
        .dime_in       (dime_in),
        .release_moore (release_moore),
        .release_reg   (release_reg)
    );

    task automatic expect_rel(input string req, input logic exp);
        n_checks++;
        if (release_moore !== exp || release_reg !== exp) begin
            n_bad++;
            $display("FAIL %s: moore=%b reg=%b expected=%b", req, release_moore, release_reg, exp);
        end
    endtask

    // Apply one cycle of input and sample after the single rising edge.
    task automatic step(input logic n, input logic d);
        nickel_in = n;
        dime_in = d;
        @(negedge clk);
        nickel_in = 1'b0;
        dime_in = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_R1();
        do_reset();
        expect_rel("R1 reset state", 1'b0);
        step(1, 0); step(1, 0);
        expect_rel("R1 two nickels after reset", 1'b0);
        step(1, 0);
        expect_rel("R1 third nickel after reset", 1'b1);
    endtask

    task automatic t_nickels_R2();
        do_reset();
        step(1, 0); expect_rel("R2 5c", 1'b0);
        step(1, 0); expect_rel("R2 10c", 1'b0);
        step(1, 0); expect_rel("R2 15c", 1'b1);
    endtask

    task automatic t_dime_nickel_R3();
        do_reset();
        step(0, 1); expect_rel("R3 10c", 1'b0);
        step(1, 0); expect_rel("R3 dime+nickel", 1'b1);
    endtask

    task automatic t_five_dime_R4();
        do_reset();
        step(1, 0);
        step(0, 1); expect_rel("R4 nickel+dime", 1'b1);
    endtask

    task automatic t_ten_dime_R5();
        do_reset();
        step(0, 1);
        step(0, 1); expect_rel("R5 two dimes", 1'b1);
    endtask

    task automatic t_idle_R6();
        do_reset();
        step(0, 0); step(0, 0); expect_rel("R6 idle at 0c", 1'b0);
        step(1, 0); step(0, 0); step(0, 0);
        step(1, 0); expect_rel("R6 idle at 5c kept credit", 1'b0);
        step(0, 0); step(0, 0);
        step(1, 0); expect_rel("R6 idle at 10c kept credit", 1'b1);
        step(0, 0); expect_rel("R6 idle at 15c", 1'b1);
    endtask

    task automatic t_both_R7();
        do_reset();
        step(1, 1); expect_rel("R7 both -> 10c no release", 1'b0);
        step(1, 0); expect_rel("R7 both counted as dime", 1'b1);
        do_reset();
        step(1, 0);
        step(1, 1); expect_rel("R7 both from 5c", 1'b1);
    endtask

    task automatic t_sticky_R8();
        do_reset();
        step(0, 1); step(0, 1);
        step(1, 0); expect_rel("R8 nickel in full", 1'b1);
        step(0, 1); expect_rel("R8 dime in full", 1'b1);
        step(1, 1); expect_rel("R8 both in full", 1'b1);
    endtask

    task automatic t_same_edge_R9();
        do_reset();
        step(1, 0); step(1, 0);
        expect_rel("R9 before entry", 1'b0);
        step(1, 0);
        expect_rel("R9 both rise together", 1'b1);
    endtask

    task automatic t_reset_release_R10();
        do_reset();
        step(0, 1); step(0, 1);
        rst = 1'b1;
        nickel_in = 1'b1;
        @(negedge clk);
        nickel_in = 1'b0;
        expect_rel("R10 reset during release", 1'b0);
        rst = 1'b0;
        step(0, 0);
        expect_rel("R10 stays low after reset", 1'b0);
    endtask

    task automatic t_onehot_R11();
        // State encoding is checked by property; observe a full cycle of sales.
        for (int i = 0; i < 3; i++) begin
            do_reset();
            step(1, 0); step(0, 1);
            expect_rel("R11 repeated sale", 1'b1);
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset_R1();
        t_nickels_R2();
        t_dime_nickel_R3();
        t_five_dime_R4();
        t_ten_dime_R5();
        t_idle_R6();
        t_both_R7();
        t_sticky_R8();
        t_same_edge_R9();
        t_reset_release_R10();
        t_onehot_R11();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule